// File: doc/BRIEF.md
# Interface interrupt and counter control

This block sits between a host bus and a parallel peripheral port. It keeps the host-written control word that decides which events may interrupt the host. It owns a transfer word counter, loaded from a separate holding register that the host writes. It also turns six general-purpose control bits into active-low output lines that the peripheral can use as it likes. A single request flip-flop collects three sources: counter-at-zero, peripheral-end and peripheral attention. The host interrupt line is that flip-flop gated by a global interrupt-enable flip-flop.

The counter is managed through two level-sensitive control bits. While the reset bit is set, the counter is cleared and kept at zero. While the load bit is set, the counter tracks the holding register. When both are clear, each completed word strobe counts the counter down, and it stops at zero. Loading while the external handshake is busy leaves the count untrustworthy, so a sticky status flag records it until the next counter reset. The data FIFO and the handshake engine lie outside this block. The only link to them is a busy input.

Top module: `pio_irq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the counter, holding register, request, attention, peripheral-end, interrupt-enable and counter-invalid state are all 0. The control word resets to 12'h018, so both interrupt-disable bits are 1. All six `ctl_n` lines are 1 and `host_irq` is 0.
- R2: The control word `ctl_wdata[11:0]` is captured on a clock edge with `ctl_we`. Control bits 2..0 drive `ctl_n[2:0]` and bits 10..8 drive `ctl_n[5:3]`, each inverted, so a 1 gives a low line. Nothing else in the block reacts to these six bits.
- R3: While control bit 6 (counter reset) is 1, the counter is 0 on the next edge and stays there, whatever the strobe or the load bit does. The holding register keeps its value.
- R4: While control bit 5 (load) is 1 and bit 6 is 0, the counter takes the holding register value on every edge. This includes a holding value written while the load is held.
- R5: With bits 5 and 6 both 0, each cycle with `word_strobe` high decrements the counter by one. At zero the counter stays at zero. `cnt_zero` is high exactly when the count is zero.
- R6: When the count is zero and control bit 3 (zero-count disable) is 0, the request flip-flop is set on the next edge. With bit 3 at 1 this path is blocked. Changing bit 3 never alters the count.
- R7: `periph_end` sets the peripheral-end flip-flop, and control bit 11 holds that flip-flop clear while it is 1. If the flip-flop is set and control bit 4 (peripheral-end disable) is 0, the request flip-flop is set on the next edge.
- R8: While control bit 7 (attention enable) is 0, the attention flip-flop is held clear. While bit 7 is 1, `periph_attn` sets it. A set attention flip-flop sets the request flip-flop on the next edge.
- R9: `host_irq` is high only while both the request flip-flop and the interrupt-enable flip-flop are set. The interrupt-enable flip-flop is written through `ie_we`/`ie_wdata`.
- R10: Holding the load bit while `hs_busy` is high sets `cnt_invalid` on the next edge. The flag stays set until the counter reset bit is applied.
- R11: A `host_ack` cycle clears the request flip-flop on the next edge and takes priority over any set condition in that cycle. A condition that is still present sets it again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 12 | Control word value |
| hold_we | input | 1 | Holding register write strobe |
| hold_wdata | input | 16 | Holding register value |
| ie_we | input | 1 | Interrupt-enable write strobe |
| ie_wdata | input | 1 | Interrupt-enable value |
| word_strobe | input | 1 | One completed word transfer |
| hs_busy | input | 1 | Handshake in progress |
| periph_end | input | 1 | Peripheral end request |
| periph_attn | input | 1 | Peripheral attention request |
| host_ack | input | 1 | Host acknowledge, clears the request |
| host_irq | output | 1 | Gated interrupt request to host |
| cnt_value | output | 16 | Current transfer count |
| cnt_zero | output | 1 | Count equals zero |
| cnt_invalid | output | 1 | Sticky flag for a load made during a handshake |
| pend_flag | output | 1 | Peripheral-end flip-flop |
| attn_flag | output | 1 | Attention flip-flop |
| ctl_n | output | 6 | Active-low general-purpose control lines |

## Verification
The hardest situation to reach is a request source that stays present while the host acknowledges. Here the acknowledge has to win for exactly one edge, and the request comes back on the following edge. The stimulus gets there by first counting the counter down to zero through the strobe sequence. It then clears the zero-count disable bit with interrupts enabled and pulses `host_ack` while the zero condition persists, sampling `host_irq` on the two edges that follow. The sticky invalid flag is reached in a similar way: the load bit is held while `hs_busy` is high, and the bench then shows that only a counter reset, and no later clean load, clears the flag.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;

  localparam int CTL_W = 12;

  // Control word layout, MSB first
  typedef struct packed {
    logic       pend_clr;   // 11: hold peripheral-end flop clear
    logic [2:0] out_hi;     // 10..8: control lines 5..3
    logic       attn_en;    // 7
    logic       cnt_rst;    // 6
    logic       cnt_load;   // 5
    logic       pe_dis;     // 4
    logic       zc_dis;     // 3
    logic [2:0] out_lo;     // 2..0: control lines 2..0
  } ctl_t;

  localparam ctl_t CTL_RESET = ctl_t'(12'h018);

  // bit position in the control word of general-purpose line i
  function automatic int unsigned out_pos(input int unsigned i);
    return (i < 3) ? i : i + 5;
  endfunction

endpackage

// File: rtl/pio_ctl_reg.sv
module pio_ctl_reg
  import pio_irq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_GP = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ctl_we,
  input  logic [CTL_W-1:0]           ctl_wdata,
  input  logic                       hold_we,
  input  logic [CNT_W-1:0]           hold_wdata,
  input  logic                       ie_we,
  input  logic                       ie_wdata,
  output ctl_t                       ctl_q,
  output logic [CNT_W-1:0]           hold_q,
  output logic                       ie_q,
  output logic [NUM_GP-1:0]          ctl_n
);

  logic [CTL_W-1:0] ctl_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RESET;
      hold_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (ctl_we)  ctl_q  <= ctl_t'(ctl_wdata);
      if (hold_we) hold_q <= hold_wdata;
      if (ie_we)   ie_q   <= ie_wdata;
    end
  end

  assign ctl_bits = ctl_q;

  for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
    localparam int unsigned P = out_pos(i);
    assign ctl_n[i] = ~ctl_bits[P];
  end

endmodule

// File: rtl/pio_word_counter.sv
module pio_word_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_rst,
  input  logic             cnt_load,
  input  logic             strobe,
  input  logic             hs_busy,
  input  logic [CNT_W-1:0] hold,
  output logic [CNT_W-1:0] cnt,
  output logic             zero,
  output logic             invalid,
  output logic             ev_bad_load
);

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] src,
    input logic             clr,
    input logic             ld,
    input logic             stb
  );
    if (clr)                   return '0;
    if (ld)                    return src;
    if (stb && (cur != '0))    return cur - CNT_W'(1);
    return cur;
  endfunction

  assign ev_bad_load = cnt_load & hs_busy;
  assign zero        = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      invalid <= 1'b0;
    end else begin
      cnt <= next_count(cnt, hold, cnt_rst, cnt_load, strobe);
      if (cnt_rst)          invalid <= 1'b0;
      else if (ev_bad_load) invalid <= 1'b1;
    end
  end

endmodule

// File: rtl/pio_req_logic.sv
module pio_req_logic (
  input  logic clk,
  input  logic rst,
  input  logic pend_clr,
  input  logic periph_end,
  input  logic attn_en,
  input  logic periph_attn,
  input  logic cnt_zero,
  input  logic zc_dis,
  input  logic pe_dis,
  input  logic host_ack,
  input  logic ie_q,
  output logic pend_q,
  output logic attn_q,
  output logic req_q,
  output logic ev_zero,
  output logic host_irq
);

  logic ev_pend;
  logic ev_set;

  assign ev_zero = cnt_zero & ~zc_dis;
  assign ev_pend = pend_q & ~pe_dis;
  assign ev_set  = ev_zero | ev_pend | attn_q;

  always_ff @(posedge clk) begin
    if (rst || pend_clr) pend_q <= 1'b0;
    else if (periph_end) pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !attn_en)  attn_q <= 1'b0;
    else if (periph_attn) attn_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || host_ack) req_q <= 1'b0;
    else if (ev_set)     req_q <= 1'b1;
  end

  assign host_irq = req_q & ie_q;

endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
  import pio_irq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_GP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              hold_we,
  input  logic [CNT_W-1:0]  hold_wdata,
  input  logic              ie_we,
  input  logic              ie_wdata,
  input  logic              word_strobe,
  input  logic              hs_busy,
  input  logic              periph_end,
  input  logic              periph_attn,
  input  logic              host_ack,
  output logic              host_irq,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              cnt_zero,
  output logic              cnt_invalid,
  output logic              pend_flag,
  output logic              attn_flag,
  output logic [NUM_GP-1:0] ctl_n
);

  ctl_t             ctl_q;
  logic [CNT_W-1:0] hold_q;
  logic             ie_q;
  logic             req_q;
  logic             ev_zero;
  logic             ev_bad_load;

  pio_ctl_reg #(.CNT_W(CNT_W), .NUM_GP(NUM_GP)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .hold_we    (hold_we),
    .hold_wdata (hold_wdata),
    .ie_we      (ie_we),
    .ie_wdata   (ie_wdata),
    .ctl_q      (ctl_q),
    .hold_q     (hold_q),
    .ie_q       (ie_q),
    .ctl_n      (ctl_n)
  );

  pio_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .cnt_rst     (ctl_q.cnt_rst),
    .cnt_load    (ctl_q.cnt_load),
    .strobe      (word_strobe),
    .hs_busy     (hs_busy),
    .hold        (hold_q),
    .cnt         (cnt_value),
    .zero        (cnt_zero),
    .invalid     (cnt_invalid),
    .ev_bad_load (ev_bad_load)
  );

  pio_req_logic u_req (
    .clk         (clk),
    .rst         (rst),
    .pend_clr    (ctl_q.pend_clr),
    .periph_end  (periph_end),
    .attn_en     (ctl_q.attn_en),
    .periph_attn (periph_attn),
    .cnt_zero    (cnt_zero),
    .zc_dis      (ctl_q.zc_dis),
    .pe_dis      (ctl_q.pe_dis),
    .host_ack    (host_ack),
    .ie_q        (ie_q),
    .pend_q      (pend_flag),
    .attn_q      (attn_flag),
    .req_q       (req_q),
    .ev_zero     (ev_zero),
    .host_irq    (host_irq)
  );

endmodule

// File: rtl/pio_irq_ctrl_chk.sv
module pio_irq_ctrl_chk
  import pio_irq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input ctl_t             ctl_q,
  input logic [CNT_W-1:0] hold_q,
  input logic             ie_q,
  input logic             req_q,
  input logic             ev_zero,
  input logic             ev_bad_load,
  input logic [CNT_W-1:0] cnt_value,
  input logic             cnt_invalid,
  input logic             word_strobe,
  input logic             host_ack,
  input logic             host_irq,
  input logic             pend_flag,
  input logic             attn_flag
);

  a_r3_reset_holds_zero: assert property (@(posedge clk) disable iff (rst)
    ctl_q.cnt_rst |=> (cnt_value == '0));

  a_r4_load_tracks_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.cnt_load && !ctl_q.cnt_rst) |=> (cnt_value == $past(hold_q)));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    ((cnt_value == '0) && !ctl_q.cnt_load) |=> (cnt_value == '0));

  a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
    (word_strobe && !ctl_q.cnt_load && !ctl_q.cnt_rst && (cnt_value != '0))
      |=> (cnt_value == $past(cnt_value) - CNT_W'(1)));

  a_r6_zero_sets_req: assert property (@(posedge clk) disable iff (rst)
    (ev_zero && !host_ack) |=> req_q);

  a_r7_pend_held_clear: assert property (@(posedge clk) disable iff (rst)
    ctl_q.pend_clr |=> !pend_flag);

  a_r8_attn_held_clear: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.attn_en |=> !attn_flag);

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> (ie_q && req_q));

  a_r10_bad_load_flags: assert property (@(posedge clk) disable iff (rst)
    ev_bad_load && !ctl_q.cnt_rst |=> cnt_invalid);

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (cnt_invalid && !ctl_q.cnt_rst) |=> cnt_invalid);

  a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !req_q);

endmodule

bind pio_irq_ctrl pio_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_q       (ctl_q),
  .hold_q      (hold_q),
  .ie_q        (ie_q),
  .req_q       (req_q),
  .ev_zero     (ev_zero),
  .ev_bad_load (ev_bad_load),
  .cnt_value   (cnt_value),
  .cnt_invalid (cnt_invalid),
  .word_strobe (word_strobe),
  .host_ack    (host_ack),
  .host_irq    (host_irq),
  .pend_flag   (pend_flag),
  .attn_flag   (attn_flag)
);

// File: tb/pio_irq_ctrl_tb.sv
module pio_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [11:0] ctl_wdata = '0;
  logic        hold_we = 1'b0;
  logic [15:0] hold_wdata = '0;
  logic        ie_we = 1'b0;
  logic        ie_wdata = 1'b0;
  logic        word_strobe = 1'b0;
  logic        hs_busy = 1'b0;
  logic        periph_end = 1'b0;
  logic        periph_attn = 1'b0;
  logic        host_ack = 1'b0;
  logic        host_irq;
  logic [15:0] cnt_value;
  logic        cnt_zero;
  logic        cnt_invalid;
  logic        pend_flag;
  logic        attn_flag;
  logic [5:0]  ctl_n;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .hold_we(hold_we), .hold_wdata(hold_wdata), .ie_we(ie_we), .ie_wdata(ie_wdata),
    .word_strobe(word_strobe), .hs_busy(hs_busy), .periph_end(periph_end),
    .periph_attn(periph_attn), .host_ack(host_ack), .host_irq(host_irq),
    .cnt_value(cnt_value), .cnt_zero(cnt_zero), .cnt_invalid(cnt_invalid),
    .pend_flag(pend_flag), .attn_flag(attn_flag), .ctl_n(ctl_n)
  );

  // {strobe, expected count after the edge}, starting from a count of 5
  localparam logic [16:0] CNT_VEC [8] = '{
    17'h1_0004, 17'h0_0004, 17'h1_0003, 17'h1_0002,
    17'h1_0001, 17'h0_0001, 17'h1_0000, 17'h1_0000
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [11:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic wr_hold(input logic [15:0] v);
    hold_we = 1'b1; hold_wdata = v;
    step();
    hold_we = 1'b0;
  endtask

  task automatic wr_ie(input logic v);
    ie_we = 1'b1; ie_wdata = v;
    step();
    ie_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    // R1 reset state
    check("R1 cnt", cnt_value, 0);
    check("R1 irq", host_irq, 0);
    check("R1 ctl_n", ctl_n, 6'h3F);
    check("R1 invalid", cnt_invalid, 0);
    check("R1 flags", {pend_flag, attn_flag}, 0);
    step();
    check("R1 no request at zero count", host_irq, 0);

    // R2 control lines
    wr_ctl(12'h21D);
    check("R2 lines", ctl_n, 6'b101010);
    check("R2 no side effect", cnt_value, 0);
    wr_ctl(12'h018);
    check("R2 lines released", ctl_n, 6'h3F);

    // R4 load tracking
    wr_hold(16'd3);
    wr_ctl(12'h038);
    step();
    check("R4 load", cnt_value, 3);
    check("R10 clean load", cnt_invalid, 0);
    wr_hold(16'd5);
    step();
    check("R4 follows hold", cnt_value, 5);
    wr_ctl(12'h018);
    check("R4 released", cnt_value, 5);

    // R5 table walk
    for (int k = 0; k < 8; k++) begin
      word_strobe = CNT_VEC[k][16];
      step();
      check("R5 count", cnt_value, {16'h0, CNT_VEC[k][15:0]});
      check("R5 zero", cnt_zero, CNT_VEC[k][15:0] == 16'h0);
    end
    word_strobe = 1'b0;

    // R6 / R9 zero-count request
    wr_ie(1'b1);
    check("R6 disabled path", host_irq, 0);
    wr_ctl(12'h010);
    step();
    check("R6 zero request", host_irq, 1);
    wr_ie(1'b0);
    check("R9 gated off", host_irq, 0);
    wr_ie(1'b1);
    check("R9 gated on", host_irq, 1);

    // R11 ack priority, then re-set
    host_ack = 1'b1;
    step();
    host_ack = 1'b0;
    check("R11 ack clears", host_irq, 0);
    step();
    check("R11 re-set by persistent zero", host_irq, 1);
    wr_ctl(12'h018);
    host_ack = 1'b1;
    step();
    host_ack = 1'b0;
    step();
    check("R11 stays clear", host_irq, 0);

    // R6 disable bit leaves count alone
    wr_ctl(12'h038);
    step();
    wr_ctl(12'h018);
    wr_ctl(12'h010);
    step();
    check("R6 count kept", cnt_value, 5);
    check("R6 nonzero no request", host_irq, 0);
    wr_ctl(12'h018);
    check("R6 count kept again", cnt_value, 5);

    // R3 counter reset holds zero, holding kept
    wr_ctl(12'h058);
    step();
    check("R3 cleared", cnt_value, 0);
    word_strobe = 1'b1;
    step();
    word_strobe = 1'b0;
    check("R3 held", cnt_value, 0);
    wr_ctl(12'h038);
    step();
    check("R3 holding kept", cnt_value, 5);
    wr_ctl(12'h018);

    // R10 sticky invalid
    hs_busy = 1'b1;
    wr_ctl(12'h038);
    step();
    check("R10 set", cnt_invalid, 1);
    hs_busy = 1'b0;
    wr_ctl(12'h038);
    step();
    wr_ctl(12'h018);
    check("R10 sticky", cnt_invalid, 1);
    wr_ctl(12'h058);
    step();
    check("R10 cleared by reset", cnt_invalid, 0);
    wr_ctl(12'h018);
    host_ack = 1'b1;
    step();
    host_ack = 1'b0;

    // R7 peripheral end
    periph_end = 1'b1;
    step();
    periph_end = 1'b0;
    check("R7 flop set", pend_flag, 1);
    step();
    check("R7 disabled path", host_irq, 0);
    wr_ctl(12'h008);
    step();
    check("R7 request", host_irq, 1);
    wr_ctl(12'h818);
    step();
    check("R7 flop cleared", pend_flag, 0);
    periph_end = 1'b1;
    step();
    periph_end = 1'b0;
    check("R7 held clear", pend_flag, 0);
    host_ack = 1'b1;
    step();
    host_ack = 1'b0;
    wr_ctl(12'h018);
    check("R7 ack", host_irq, 0);

    // R8 attention
    periph_attn = 1'b1;
    step();
    check("R8 held clear", attn_flag, 0);
    check("R8 no request", host_irq, 0);
    wr_ctl(12'h098);
    step();
    check("R8 set", attn_flag, 1);
    step();
    check("R8 request", host_irq, 1);
    periph_attn = 1'b0;
    wr_ctl(12'h018);
    step();
    check("R8 cleared by enable", attn_flag, 0);
    host_ack = 1'b1;
    step();
    host_ack = 1'b0;
    step();
    check("R8 request gone", host_irq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule